// File: doc/BRIEF.md
# Run-time formatted asynchronous serial transmitter

This block serialises bytes onto a single transmit line. An 8-bit control byte sets the frame format at run time: how many data bits the frame carries, whether a parity bit is sent and which kind, and how long the stop period lasts. The same byte also holds a break control, which pulls the line low, and a flag that grants access to the divisor. The block only presents that flag on an output.

A host writes the control byte through a one-cycle write strobe. It hands bytes over with a valid/ready handshake. Bit timing comes from an internal tick at sixteen times the baud rate, which a 16-bit divisor derives from the clock. The divisor counter restarts when each frame is accepted, so every bit lasts exactly sixteen ticks. The format is captured when a frame starts, which lets software rewrite the control byte while a frame is on the line without corrupting that frame.

Top module: `uart_fmt_tx`

## Requirements
- R1: After synchronous reset the line is 1, `tx_ready` is 1, `divlatch_access` is 0 and the control byte is 0x00.
- R2: Control bits [1:0] set the data word length to 5, 6, 7 or 8 bits (00, 01, 10, 11). Only the low bits of `tx_data` that fit the word are sent.
- R3: A frame is one start bit of 0, then data bits least significant first, then optional parity, then stop bits of 1. The line idles at 1.
- R4: With control bit [3] = 0 no parity bit is sent, whatever bits [5:4] hold.
- R5: With bit [3] = 1, bits [5:4] pick the parity bit: 00 makes the count of ones across data and parity odd, 01 makes it even, 10 sends 1 and 11 sends 0.
- R6: Bit [2] = 0 gives a stop period of 16 ticks. Bit [2] = 1 gives 32 ticks for 6-, 7- and 8-bit words and 24 ticks for 5-bit words.
- R7: A tick occurs every `baud_div` clocks. Each start, data and parity bit lasts 16 ticks, counted from the cycle after acceptance.
- R8: With `baud_div` = 0 there are no ticks, and a frame that has started holds its current bit indefinitely.
- R9: While control bit [6] = 1 the line is forced to 0. It is released as soon as the bit is cleared.
- R10: Control bit [7] appears on `divlatch_access` and has no effect on the frame.
- R11: A control write during a frame does not change that frame. The new format applies from the next accepted frame.
- R12: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` stays 0 from that edge until the stop period has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| ctrl_din | input | 8 | Control byte value |
| baud_div | input | 16 | Clocks per 16x tick; 0 stops the tick |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter is idle and can accept a byte |
| tx_line | output | 1 | Serial output |
| divlatch_access | output | 1 | Divisor access flag from control bit 7 |

## Verification
A wrong state or tick count inside this block shows up in two ways. The bit level sampled at the centre of some bit is wrong, or `tx_ready` returns in the wrong cycle. Either error can be measured within one frame, at most 12 bit periods after the start edge. A format register that is captured late or wrongly appears as a frame with the wrong length or parity. This is why each frame is compared against the control byte that was in force when it was accepted. A stuck divisor counter shows as a line frozen at the start bit.

// File: rtl/uft_pkg.sv
`timescale 1ns/1ps
package uft_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int TCNT_W        = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // bit positions of the control byte
    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic [1:0] par_sel;
        logic       par_en;
        logic       stop_long;
        logic [1:0] wsel;
    } ctrl_t;

    // part of the control byte captured per frame
    typedef struct packed {
        logic [1:0] wsel;
        logic       stop_long;
        logic       par_en;
        logic [1:0] par_sel;
    } frame_fmt_t;

    function automatic frame_fmt_t fmt_of(input ctrl_t c);
        frame_fmt_t f;
        f.wsel      = c.wsel;
        f.stop_long = c.stop_long;
        f.par_en    = c.par_en;
        f.par_sel   = c.par_sel;
        return f;
    endfunction

    function automatic logic [3:0] word_bits(input logic [1:0] wsel);
        return 4'd5 + {2'b00, wsel};
    endfunction

    // last tick index of the stop period
    function automatic logic [TCNT_W-1:0] stop_last(input frame_fmt_t f);
        if (!f.stop_long)       return 5'd15;
        else if (f.wsel == 2'b00) return 5'd23;
        else                    return 5'd31;
    endfunction

    function automatic logic [7:0] word_mask(input logic [1:0] wsel, input logic [7:0] d);
        logic [7:0] m;
        m = 8'hFF >> (3'd3 - {1'b0, wsel});
        return d & m;
    endfunction

    function automatic logic parity_bit(input frame_fmt_t f, input logic [7:0] d);
        logic ones;
        ones = ^word_mask(f.wsel, d);
        case (f.par_sel)
            2'b00:   return ~ones;
            2'b01:   return ones;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uft_baud.sv
`timescale 1ns/1ps
module uft_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (div != '0) && (cnt == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (div == '0)   cnt <= '0;
        else if (tick)        cnt <= '0;
        else                  cnt <= cnt + DIV_W'(1);
    end

    AST_DIV0_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |=> (cnt == '0)); // R8

endmodule

// File: rtl/uft_engine.sv
`timescale 1ns/1ps
module uft_engine
    import uft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       req,
    input  logic [7:0] din,
    input  frame_fmt_t fmt_in,
    output logic       ready,
    output logic       accept,
    output logic       line_raw,
    output logic       idle
);
    tx_state_e          state;
    frame_fmt_t         fmt_q;
    logic [7:0]         sh;
    logic [3:0]         bits_left;
    logic               par_q;
    logic [TCNT_W-1:0]  tcnt;
    logic [TCNT_W-1:0]  tlast;

    assign idle   = (state == ST_IDLE);
    assign ready  = idle;
    assign accept = idle && req;
    assign tlast  = (state == ST_STOP) ? stop_last(fmt_q) : TCNT_W'(TICKS_PER_BIT - 1);

    always_comb begin
        case (state)
            ST_START: line_raw = 1'b0;
            ST_DATA:  line_raw = sh[0];
            ST_PAR:   line_raw = par_q;
            default:  line_raw = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            fmt_q     <= '0;
            sh        <= '0;
            bits_left <= '0;
            par_q     <= 1'b0;
            tcnt      <= '0;
        end else if (accept) begin
            state     <= ST_START;
            fmt_q     <= fmt_in;
            sh        <= din;
            bits_left <= word_bits(fmt_in.wsel);
            par_q     <= parity_bit(fmt_in, din);
            tcnt      <= '0;
        end else if (!idle && tick) begin
            if (tcnt != tlast) begin
                tcnt <= tcnt + TCNT_W'(1);
            end else begin
                tcnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        sh        <= sh >> 1;
                        bits_left <= bits_left - 4'd1;
                        if (bits_left == 4'd1)
                            state <= fmt_q.par_en ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(fmt_q)); // R11
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !tick) |=> ($stable(state) && $stable(tcnt))); // R8
    AST_BIT_TICKS: assert property (@(posedge clk) disable iff (rst)
        (state != ST_STOP) |-> (tcnt < TCNT_W'(TICKS_PER_BIT))); // R7

endmodule

// File: rtl/uart_fmt_tx.sv
`timescale 1ns/1ps
module uart_fmt_tx
    import uft_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_din,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             tx_line,
    output logic             divlatch_access
);
    ctrl_t ctrl_q;
    logic  tick;
    logic  accept;
    logic  line_raw;
    logic  eng_idle;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_din);
    end

    uft_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .div  (baud_div),
        .tick (tick)
    );

    uft_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .req      (tx_valid),
        .din      (tx_data),
        .fmt_in   (fmt_of(ctrl_q)),
        .ready    (tx_ready),
        .accept   (accept),
        .line_raw (line_raw),
        .idle     (eng_idle)
    );

    assign tx_line         = line_raw & ~ctrl_q.brk;
    assign divlatch_access = ctrl_q.dlab;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (eng_idle && !ctrl_q.brk) |-> tx_line); // R3
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready); // R12

endmodule

// File: tb/uart_fmt_tx_bench.sv
`timescale 1ns/1ps
module uart_fmt_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_din = '0;
    logic [15:0] baud_div = 16'd2;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_line;
    logic        divlatch_access;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done_flag = 1'b0;
    logic [7:0] ctrl_model = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          div_q[$];

    always #2.5 clk = ~clk;

    uart_fmt_tx u_uart_fmt_tx (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
        .baud_div(baud_div), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_line(tx_line), .divlatch_access(divlatch_access)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, expv);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_din = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
        ctrl_model = v;
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        exp_q.push_back({ctrl_model, d});
        tag_q.push_back(tag);
        div_q.push_back(int'(baud_div));
        tx_valid = 1'b1; tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R12 ready low in frame", tx_ready, 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
    endtask

    // monitor: pops the expected frame and compares it bit by bit
    initial begin
        logic prev_line;
        prev_line = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && prev_line == 1'b1 && tx_line == 1'b0) begin
                logic [15:0] e;
                string tg;
                logic [7:0] c, d;
                logic eb[12];
                int wl, nb, stopt, b, t, cyc, dv;
                bit fin;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected start", 0, 1);
                end else begin
                    e = exp_q.pop_front(); tg = tag_q.pop_front(); dv = div_q.pop_front();
                    c = e[15:8]; d = e[7:0];
                    wl = 5 + int'(c[1:0]);
                    eb[0] = 1'b0;
                    for (int i = 0; i < 8; i++) if (i < wl) eb[1+i] = d[i];
                    nb = 1 + wl;
                    if (c[3]) begin
                        logic ones;
                        ones = 1'b0;
                        for (int i = 0; i < 8; i++) if (i < wl) ones = ones ^ d[i];
                        case (c[5:4])
                            2'b00: eb[nb] = ~ones;
                            2'b01: eb[nb] = ones;
                            2'b10: eb[nb] = 1'b1;
                            default: eb[nb] = 1'b0;
                        endcase
                        nb++;
                    end
                    stopt = !c[2] ? 16 : (wl == 5 ? 24 : 32);
                    b = 16 * dv;
                    t = nb * b + stopt * dv;
                    cyc = 0; fin = 1'b0;
                    while (!fin) begin
                        if ((cyc % b) == b / 2 && (cyc / b) < nb) begin
                            int k;
                            k = cyc / b;
                            if (k == 0)
                                chk(tx_line == 1'b0, {"R3 start bit ", tg}, tx_line, 0);
                            else if (k <= wl)
                                chk(tx_line == eb[k], {"R2 R3 data bit ", tg}, tx_line, eb[k]);
                            else
                                chk(tx_line == eb[k], {"R5 parity bit ", tg}, tx_line, eb[k]);
                        end
                        if (tx_ready || cyc > t + 20) fin = 1'b1;
                        else begin
                            @(negedge clk);
                            cyc++;
                        end
                    end
                    chk(cyc == t, {"R4 R6 R7 frame length ", tg}, cyc, t);
                    chk(tx_line == 1'b1, {"R3 idle after stop ", tg}, tx_line, 1);
                end
            end
            prev_line = tx_line;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 reset line", tx_line, 1);
        chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);
        chk(divlatch_access == 1'b0, "R1 reset flag", divlatch_access, 0);
        mon_en = 1'b1;
        // control 0x00 after reset: 5 data bits, no parity, 1 stop
        send(8'hFF, "R1 default format");
        drain();

        write_ctrl(8'h03); send(8'hA5, "R2 8N1"); send(8'h3C, "R2 8N1 b2b");
        write_ctrl(8'h01); send(8'hC9, "R2 6N1");
        write_ctrl(8'h02); send(8'h55, "R2 7N1");
        drain();
        write_ctrl(8'h04); send(8'h15, "R6 5 bits long stop");
        write_ctrl(8'h07); send(8'h81, "R6 8 bits two stop");
        write_ctrl(8'h06); send(8'h7E, "R6 7 bits two stop");
        drain();
        write_ctrl(8'h0A); send(8'h41, "R5 odd");
        write_ctrl(8'h1A); send(8'h41, "R5 even");
        write_ctrl(8'h2A); send(8'h00, "R5 forced one");
        write_ctrl(8'h3A); send(8'h7F, "R5 forced zero");
        write_ctrl(8'h0C); send(8'h0F, "R5 odd 5 bits long stop");
        write_ctrl(8'h31); send(8'h2A, "R4 sel set parity off");
        drain();

        baud_div = 16'd1;
        write_ctrl(8'h0B); send(8'h96, "R7 div 1");
        drain();
        baud_div = 16'd3;
        send(8'h69, "R7 div 3");
        drain();
        baud_div = 16'd2;

        write_ctrl(8'h83);
        chk(divlatch_access == 1'b1, "R10 flag set", divlatch_access, 1);
        send(8'hB4, "R10 frame unaffected");
        drain();
        write_ctrl(8'h03);
        chk(divlatch_access == 1'b0, "R10 flag clear", divlatch_access, 0);

        // R11: rewrite the format in mid-frame
        send(8'h5A, "R11 old format");
        repeat (40) @(negedge clk);
        write_ctrl(8'h1F);
        send(8'h5A, "R11 new format");
        drain();

        // R9 break while idle
        write_ctrl(8'h03);
        mon_en = 1'b0;
        write_ctrl(8'h43);
        repeat (5) @(negedge clk);
        chk(tx_line == 1'b0, "R9 break forces low", tx_line, 0);
        repeat (50) @(negedge clk);
        chk(tx_line == 1'b0, "R9 break held", tx_line, 0);
        write_ctrl(8'h03);
        chk(tx_line == 1'b1, "R9 break released", tx_line, 1);
        mon_en = 1'b1;

        // R8 divisor zero freezes the frame
        mon_en = 1'b0;
        baud_div = 16'd0;
        @(negedge clk);
        tx_valid = 1'b1; tx_data = 8'hFF;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (300) @(negedge clk);
        chk(tx_line == 1'b0, "R8 start bit frozen", tx_line, 0);
        chk(tx_ready == 1'b0, "R8 frame not finished", tx_ready, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ctrl_model = 8'h00;
        baud_div = 16'd2;
        @(negedge clk);
        chk(tx_ready == 1'b1 && tx_line == 1'b1, "R1 reset recovers", {tx_ready, tx_line}, 3);
        mon_en = 1'b1;
        write_ctrl(8'h03);
        send(8'hE7, "R7 after recovery");
        drain();

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule